// File: doc/BRIEF.md
# Four-Bit Command Shifter Register

This block stores a small word and, on each clock edge where it is enabled, changes that word according to a two-bit command. The four commands are: keep the word, move it one place toward the least significant bit, move it one place toward the most significant bit, or zero it. A position left empty by a move is always filled with a zero. Nothing wraps around and nothing is shifted in from outside.

A parallel load input lets a new word be written before a series of moves. Load wins over any command. The block shows the stored word on a parallel output. It also has two single-bit outputs that show the bit about to leave each end while a move is being applied. It suits datapaths that need to align or scale a word one step at a time under sequencer control.

Each edge is decoded into one named action: ACT_RESET, ACT_IDLE, ACT_LOAD, ACT_KEEP, ACT_RIGHT, ACT_LEFT or ACT_CLEAR. Any action can be followed by any other on the next edge. The command alone picks between ACT_KEEP, ACT_RIGHT, ACT_LEFT and ACT_CLEAR. Reset, a low enable and load take precedence over the command, in that order.

Top module: `cmd_shift_reg`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the stored word becomes all zeros on that edge, and both spill outputs read 0.
- R2: While `en` is low and `rst` is low, a rising edge leaves the stored word unchanged, whatever `ld`, `ld_word` and `cmd` are.
- R3: With `en` high and `ld` low, `cmd` = 2'b00 leaves the stored word unchanged on the edge.
- R4: With `en` high and `ld` low, `cmd` = 2'b01 moves every bit one place toward bit 0 on the edge and writes 0 into the top bit. For example, 0011 becomes 0001.
- R5: With `en` high and `ld` low, `cmd` = 2'b10 moves every bit one place toward the top bit on the edge and writes 0 into bit 0. For example, 0011 becomes 0110.
- R6: With `en` high and `ld` low, `cmd` = 2'b11 makes the stored word all zeros on the edge.
- R7: With `en` high, `ld` high writes `ld_word` into the stored word on the edge, whatever the value of `cmd`.
- R8: `spill_lsb` equals stored bit 0 during a cycle in which the R4 move is selected, and reads 0 in every other cycle.
- R9: `spill_msb` equals the stored top bit during a cycle in which the R5 move is selected, and reads 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables load and commands on the edge |
| ld | input | 1 | Parallel load request, wins over `cmd` |
| ld_word | input | 4 | Word written on load |
| cmd | input | 2 | 00 keep, 01 right, 10 left, 11 clear |
| word_q | output | 4 | Stored word |
| spill_lsb | output | 1 | Bit leaving bit 0 during a right move |
| spill_msb | output | 1 | Bit leaving the top bit during a left move |

## Verification
Directed cases load 0011 and then move it each way, which tells the two directions and the zero fill apart. They also move 1000 and 0001 toward their near edge, so that a spill bit of 1 shows up and the word drains to zero. Load is applied together with the clear command to show that load takes precedence. Load and every command are applied with `en` low to show that all of them are ignored. A long random run then mixes load, enable, reset and all four commands, so that every action follows every other one with varied data.

// File: rtl/cmd_shift_pkg.sv
package cmd_shift_pkg;

    typedef enum logic [1:0] {
        CMD_KEEP  = 2'b00,
        CMD_RIGHT = 2'b01,
        CMD_LEFT  = 2'b10,
        CMD_CLEAR = 2'b11
    } shift_cmd_t;

    typedef enum logic [2:0] {
        ACT_RESET,
        ACT_IDLE,
        ACT_LOAD,
        ACT_KEEP,
        ACT_RIGHT,
        ACT_LEFT,
        ACT_CLEAR
    } shift_act_t;

endpackage

// File: rtl/cmd_shift_decode.sv
module cmd_shift_decode
    import cmd_shift_pkg::*;
(
    input  logic       rst,
    input  logic       en,
    input  logic       ld,
    input  logic [1:0] cmd,
    output shift_act_t act
);

    always_comb begin
        if (rst) begin
            act = ACT_RESET;
        end else if (!en) begin
            act = ACT_IDLE;
        end else if (ld) begin
            act = ACT_LOAD;
        end else begin
            unique case (shift_cmd_t'(cmd))
                CMD_KEEP:  act = ACT_KEEP;
                CMD_RIGHT: act = ACT_RIGHT;
                CMD_LEFT:  act = ACT_LEFT;
                CMD_CLEAR: act = ACT_CLEAR;
                default:   act = ACT_KEEP;
            endcase
        end
    end

endmodule

// File: rtl/cmd_shift_next.sv
module cmd_shift_next
    import cmd_shift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  shift_act_t       act,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] ld_word,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] to_lsb;
    logic [WIDTH-1:0] to_msb;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == TOP) begin : g_top
            assign to_lsb[i] = 1'b0;
        end else begin : g_low
            assign to_lsb[i] = cur[i+1];
        end
        if (i == 0) begin : g_zero
            assign to_msb[i] = 1'b0;
        end else begin : g_high
            assign to_msb[i] = cur[i-1];
        end
    end

    always_comb begin
        unique case (act)
            ACT_RESET: nxt = '0;
            ACT_IDLE:  nxt = cur;
            ACT_LOAD:  nxt = ld_word;
            ACT_KEEP:  nxt = cur;
            ACT_RIGHT: nxt = to_lsb;
            ACT_LEFT:  nxt = to_msb;
            ACT_CLEAR: nxt = '0;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/cmd_shift_reg.sv
module cmd_shift_reg
    import cmd_shift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_word,
    input  logic [1:0]       cmd,
    output logic [WIDTH-1:0] word_q,
    output logic             spill_lsb,
    output logic             spill_msb
);

    localparam int TOP = WIDTH - 1;

    shift_act_t       act;
    logic [WIDTH-1:0] nxt;

    cmd_shift_decode u_dec (
        .rst (rst),
        .en  (en),
        .ld  (ld),
        .cmd (cmd),
        .act (act)
    );

    cmd_shift_next #(.WIDTH(WIDTH)) u_nxt (
        .act     (act),
        .cur     (word_q),
        .ld_word (ld_word),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        word_q <= nxt;
    end

    always_comb begin
        spill_lsb = 1'b0;
        spill_msb = 1'b0;
        unique case (act)
            ACT_RIGHT: spill_lsb = word_q[0];
            ACT_LEFT:  spill_msb = word_q[TOP];
            default: begin
                spill_lsb = 1'b0;
                spill_msb = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cmd_shift_chk.sv
module cmd_shift_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             ld,
    input logic [WIDTH-1:0] ld_word,
    input logic [1:0]       cmd,
    input logic [WIDTH-1:0] word_q,
    input logic             spill_lsb,
    input logic             spill_msb
);

    localparam int TOP = WIDTH - 1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (word_q == '0));

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word_q));

    assert_keep_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && cmd == 2'b00) |=> $stable(word_q));

    assert_right_move_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && cmd == 2'b01) |=>
            (word_q[TOP] == 1'b0 && word_q[TOP-1:0] == $past(word_q[TOP:1])));

    assert_left_move_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && cmd == 2'b10) |=>
            (word_q[0] == 1'b0 && word_q[TOP:1] == $past(word_q[TOP-1:0])));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !ld && cmd == 2'b11) |=> (word_q == '0));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (en && ld) |=> (word_q == $past(ld_word)));

    assert_spill_lsb_R8: assert property (@(posedge clk)
        spill_lsb |-> (!rst && en && !ld && cmd == 2'b01 && word_q[0]));

    assert_spill_msb_R9: assert property (@(posedge clk)
        spill_msb |-> (!rst && en && !ld && cmd == 2'b10 && word_q[TOP]));

endmodule

bind cmd_shift_reg cmd_shift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ld        (ld),
    .ld_word   (ld_word),
    .cmd       (cmd),
    .word_q    (word_q),
    .spill_lsb (spill_lsb),
    .spill_msb (spill_msb)
);

// File: tb/tb_cmd_shift_reg.sv
`timescale 1ns/1ps
module tb_cmd_shift_reg;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         ld = 1'b0;
    logic [W-1:0] ld_word = '0;
    logic [1:0]   cmd = 2'b00;
    logic [W-1:0] word_q;
    logic         spill_lsb;
    logic         spill_msb;

    int     n_run = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    logic [W-1:0] model = '0;
    string  last_tag = "R1";

    always #2.5 clk = ~clk;

    cmd_shift_reg #(.WIDTH(W)) dut (
        .clk (clk), .rst (rst), .en (en), .ld (ld), .ld_word (ld_word),
        .cmd (cmd), .word_q (word_q), .spill_lsb (spill_lsb), .spill_msb (spill_msb)
    );

    function automatic logic [W-1:0] ref_next(logic r, logic e, logic l,
                                              logic [W-1:0] d, logic [1:0] c,
                                              logic [W-1:0] q);
        if (r) return '0;
        if (!e) return q;
        if (l) return d;
        case (c)
            2'b01:   return q >> 1;
            2'b10:   return q << 1;
            2'b11:   return '0;
            default: return q;
        endcase
    endfunction

    function automatic string ref_tag(logic r, logic e, logic l, logic [1:0] c);
        if (r) return "R1";
        if (!e) return "R2";
        if (l) return "R7";
        case (c)
            2'b01:   return "R4";
            2'b10:   return "R5";
            2'b11:   return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act_v, logic [W-1:0] exp_v);
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act_v, exp_v);
        end
    endtask

    // One edge: check the word left by the previous edge, drive, check spills.
    task automatic step(logic r, logic e, logic l, logic [W-1:0] d, logic [1:0] c);
        logic exp_r;
        logic exp_l;
        @(negedge clk);
        check(last_tag, word_q, model);
        rst = r; en = e; ld = l; ld_word = d; cmd = c;
        exp_r = (!r && e && !l && c == 2'b01) ? model[0] : 1'b0;
        exp_l = (!r && e && !l && c == 2'b10) ? model[W-1] : 1'b0;
        #1;
        check("R8", {3'b000, spill_lsb}, {3'b000, exp_r});
        check("R9", {3'b000, spill_msb}, {3'b000, exp_l});
        last_tag = ref_tag(r, e, l, c);
        model = ref_next(r, e, l, d, c, model);
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(1, 0, 0, 4'b0000, 2'b00);          // R1 reset
        step(1, 1, 1, 4'b1111, 2'b00);          // R1 reset wins over load
        step(0, 1, 1, 4'b0011, 2'b10);          // R7 load over left
        step(0, 1, 0, 4'b0000, 2'b01);          // R4 0011 -> 0001, spill 1
        step(0, 1, 1, 4'b0011, 2'b11);          // R7 load over clear
        step(0, 1, 0, 4'b0000, 2'b10);          // R5 0011 -> 0110
        step(0, 1, 0, 4'b0000, 2'b00);          // R3 keep
        step(0, 0, 1, 4'b1001, 2'b11);          // R2 ignored with en low
        step(0, 0, 0, 4'b0000, 2'b01);          // R2
        step(0, 1, 1, 4'b1000, 2'b00);          // R7
        step(0, 1, 0, 4'b0000, 2'b10);          // R5 1000 -> 0000, spill 1
        step(0, 1, 1, 4'b0001, 2'b00);
        step(0, 1, 0, 4'b0000, 2'b01);          // R4 0001 -> 0000, spill 1
        step(0, 1, 1, 4'b1111, 2'b00);
        step(0, 1, 0, 4'b0000, 2'b11);          // R6 clear
        for (int i = 0; i < 400; i++) begin
            logic r, e, l;
            r = ($urandom % 20) == 0;
            e = ($urandom % 5) != 0;
            l = ($urandom % 4) == 0;
            step(r, e, l, W'($urandom), 2'($urandom));
        end
        step(0, 0, 0, 4'b0000, 2'b00);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule